// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller. Pins are grouped into banks of up to 32. Each bank has its own register set on a simple word bus with an address, write data, a write strobe, a read strobe and registered read data. Software sets the direction of each pin. It drives output levels only through separate write-one-to-set and write-one-to-clear ports. Reading the level register returns the synchronized state of every pad, whether the pad is an input or an output.

Every pad input passes through a two-flop synchronizer. The block compares the synchronized value with its value one cycle earlier to find rising and falling transitions. A transition sets a sticky per-pin status bit when the matching rising or falling enable bit is set. Writing a one to a status bit clears it. A per-bank mask gates status bits onto the interrupt outputs. All unmasked status bits of all banks are ORed into one combined interrupt, and bank 0 pins 0 and 1 each drive a dedicated interrupt line as well.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every output, edge enable, edge status and mask bit is zero, and the combined and dedicated interrupts are low. Every direction bit resets to the pin's bit of the DIR_INV parameter, so that no pad output enable is asserted.
- R2: Bank b starts at byte address (b/3)*0x100 + (b%3)*4. Within a bank the offsets are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, status 0x48, mask 0x9C. Reads of the set and clear offsets, and of unmapped addresses, return zero. Read data is valid in the cycle after the read strobe.
- R3: Writing the set offset makes each pad output whose data bit is 1 go high from the next cycle. Pad outputs whose data bit is 0 keep their value.
- R4: Writing the clear offset makes each pad output whose data bit is 1 go low from the next cycle. Pad outputs whose data bit is 0 keep their value.
- R5: A pad's output enable equals its direction bit XOR its DIR_INV bit, where a direction bit of 1 means output on a pin that is not inverted.
- R6: The level register returns the pad inputs after a two-flop synchronizer, for inputs and outputs alike.
- R7: A synchronized 0-to-1 transition sets a pin's status bit when its rising enable is 1. A 1-to-0 transition sets it when its falling enable is 1. A transition with its enable at 0 leaves the bit unchanged.
- R8: Writing the status offset clears each status bit whose data bit is 1. Bits written 0 keep their value. Status bits stay set until cleared.
- R9: If a transition that sets a status bit occurs in the same cycle as a write that clears that bit, the bit ends up set.
- R10: A status bit reaches the interrupt outputs only while its mask bit is 1. Status is recorded whatever the mask.
- R11: irq_any is the OR of status AND mask over all banks. irq_pin0 and irq_pin1 are the masked status of bank 0 bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | PINS | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | PINS | Read data, valid the cycle after bus_rd |
| pad_in | input | NUM_BANKS*PINS | Pad input levels, asynchronous |
| pad_out | output | NUM_BANKS*PINS | Pad output levels |
| pad_oe | output | NUM_BANKS*PINS | Pad output enables |
| irq_any | output | 1 | Combined masked edge interrupt |
| irq_pin0 | output | 1 | Masked edge interrupt of bank 0 pin 0 |
| irq_pin1 | output | 1 | Masked edge interrupt of bank 0 pin 1 |

## Verification
The two functions that can meet in one cycle are edge capture and the write-one-to-clear of the status register. The bench raises a pad, counts the two synchronizer stages and the edge compare, and issues the clearing write so that its clock edge is the same one that records the transition. It then reads the status back and requires the bit to be set, and a second clear must bring it to zero. Masking is judged at the interrupt pins while the status read still shows the recorded edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int unsigned OFF_LVL  = 'h00;
   localparam int unsigned OFF_DIR  = 'h0C;
   localparam int unsigned OFF_SET  = 'h18;
   localparam int unsigned OFF_CLR  = 'h24;
   localparam int unsigned OFF_REN  = 'h30;
   localparam int unsigned OFF_FEN  = 'h3C;
   localparam int unsigned OFF_STS  = 'h48;
   localparam int unsigned OFF_MSK  = 'h9C;
   localparam int unsigned GROUP_SZ = 3;
   localparam int unsigned GROUP_SPAN = 'h100;

   // Byte base of a bank: three banks share one block, word-interleaved
   function automatic int unsigned bank_base(input int unsigned b);
      return (b / GROUP_SZ) * GROUP_SPAN + (b % GROUP_SZ) * 4;
   endfunction
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
   parameter int unsigned PINS = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] pad_in,
   output logic [PINS-1:0] lvl,
   output logic [PINS-1:0] rise,
   output logic [PINS-1:0] fall
);
   logic [PINS-1:0] meta_q, sync_q, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= pad_in;
         sync_q <= meta_q;
         prev_q <= sync_q;
      end
   end

   assign lvl  = sync_q;
   assign rise = sync_q & ~prev_q;
   assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned BANK_IDX = 0,
   parameter int unsigned PINS     = 32,
   parameter int unsigned ADDR_W   = 12,
   parameter logic [PINS-1:0] INV  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PINS-1:0]   wdata,
   input  logic              wr,
   input  logic [PINS-1:0]   pad_in,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pad_oe,
   output logic [PINS-1:0]   rd_word,
   output logic [PINS-1:0]   irq_vec
);
   localparam int unsigned BASE = bank_base(BANK_IDX);
   localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(BASE + OFF_LVL);
   localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(BASE + OFF_DIR);
   localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(BASE + OFF_SET);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(BASE + OFF_CLR);
   localparam logic [ADDR_W-1:0] A_REN = ADDR_W'(BASE + OFF_REN);
   localparam logic [ADDR_W-1:0] A_FEN = ADDR_W'(BASE + OFF_FEN);
   localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(BASE + OFF_STS);
   localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(BASE + OFF_MSK);

   logic [PINS-1:0] dir_q, out_q, ren_q, fen_q, sts_q, msk_q;
   logic [PINS-1:0] lvl, rise, fall, w1c, hits;

   gpio_edge_sync #(.PINS(PINS)) u_sync (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
      .lvl(lvl), .rise(rise), .fall(fall)
   );

   // Clear pattern applies first, new events are ORed afterwards
   assign w1c  = (wr && addr == A_STS) ? wdata : '0;
   assign hits = (rise & ren_q) | (fall & fen_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= INV;
         out_q <= '0;
         ren_q <= '0;
         fen_q <= '0;
         sts_q <= '0;
         msk_q <= '0;
      end else begin
         sts_q <= (sts_q & ~w1c) | hits;
         if (wr) begin
            unique case (addr)
               A_DIR:   dir_q <= wdata;
               A_SET:   out_q <= out_q | wdata;
               A_CLR:   out_q <= out_q & ~wdata;
               A_REN:   ren_q <= wdata;
               A_FEN:   fen_q <= wdata;
               A_MSK:   msk_q <= wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (addr)
         A_LVL:   rd_word = lvl;
         A_DIR:   rd_word = dir_q;
         A_REN:   rd_word = ren_q;
         A_FEN:   rd_word = fen_q;
         A_STS:   rd_word = sts_q;
         A_MSK:   rd_word = msk_q;
         default: rd_word = '0;
      endcase
   end

   assign pad_out = out_q;
   assign pad_oe  = dir_q ^ INV;
   assign irq_vec = sts_q & msk_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned PINS      = 32,
   parameter int unsigned ADDR_W    = 12,
   parameter logic [NUM_BANKS*PINS-1:0] DIR_INV = '0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [PINS-1:0]           bus_wdata,
   input  logic                      bus_wr,
   input  logic                      bus_rd,
   output logic [PINS-1:0]           bus_rdata,
   input  logic [NUM_BANKS*PINS-1:0] pad_in,
   output logic [NUM_BANKS*PINS-1:0] pad_out,
   output logic [NUM_BANKS*PINS-1:0] pad_oe,
   output logic                      irq_any,
   output logic                      irq_pin0,
   output logic                      irq_pin1
);
   localparam int unsigned NP       = NUM_BANKS * PINS;
   localparam int unsigned TOP_ADDR = bank_base(NUM_BANKS - 1) + OFF_MSK;

   if (PINS < 2 || PINS > 32) begin : g_bad_pins
      $error("gpio_bank_ctrl: PINS must lie in 2..32");
   end
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("gpio_bank_ctrl: NUM_BANKS must be at least 1");
   end
   if (TOP_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_bank_ctrl: ADDR_W too narrow for NUM_BANKS");
   end

   logic [PINS-1:0] rd_words [NUM_BANKS];
   logic [PINS-1:0] irq_vecs [NUM_BANKS];
   logic [PINS-1:0] rd_or;
   logic            any_or;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      gpio_bank #(
         .BANK_IDX(b), .PINS(PINS), .ADDR_W(ADDR_W),
         .INV(DIR_INV[b*PINS +: PINS])
      ) u_bank (
         .clk(clk), .rst_n(rst_n),
         .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
         .pad_in(pad_in[b*PINS +: PINS]),
         .pad_out(pad_out[b*PINS +: PINS]),
         .pad_oe(pad_oe[b*PINS +: PINS]),
         .rd_word(rd_words[b]),
         .irq_vec(irq_vecs[b])
      );
   end

   always_comb begin
      rd_or  = '0;
      any_or = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         rd_or  = rd_or | rd_words[b];
         any_or = any_or | (|irq_vecs[b]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_or;
   end

   assign irq_any  = any_or;
   assign irq_pin0 = irq_vecs[0][0];
   assign irq_pin1 = irq_vecs[0][1];

   // NP kept for width documentation of the pad vectors
   logic [NP-1:0] unused_np;
   assign unused_np = '0;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
   import gpio_bank_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wdata0,
   input logic              bus_wr,
   input logic              out0,
   input logic              irq_any,
   input logic              irq_pin0,
   input logic              irq_pin1
);
   localparam logic [ADDR_W-1:0] SET0 = ADDR_W'(OFF_SET);
   localparam logic [ADDR_W-1:0] CLR0 = ADDR_W'(OFF_CLR);

   AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == SET0 && wdata0) |=> out0); // R3
   AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CLR0 && wdata0) |=> !out0); // R4
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pin0 && !bus_wr) |=> irq_pin0); // R8
   AST_PIN0_IN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pin0 |-> irq_any); // R11
   AST_PIN1_IN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pin1 |-> irq_any); // R11
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wdata0(bus_wdata[0]),
   .bus_wr(bus_wr), .out0(pad_out[0]), .irq_any(irq_any),
   .irq_pin0(irq_pin0), .irq_pin1(irq_pin1)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;
   localparam int unsigned NB = 4;
   localparam int unsigned PW = 32;
   localparam int unsigned AW = 12;
   localparam int unsigned NP = NB * PW;
   localparam logic [NP-1:0] INV = 128'h00000000_00000000_0000F000_00000000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [PW-1:0] bus_wdata = '0, bus_rdata;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [NP-1:0] pad_in, pad_out, pad_oe, ext_in = '0;
   logic irq_any, irq_pin0, irq_pin1;

   always #2.5 clk = ~clk;

   assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_in);

   gpio_bank_ctrl #(.NUM_BANKS(NB), .PINS(PW), .ADDR_W(AW), .DIR_INV(INV)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .irq_any(irq_any), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1)
   );

   typedef struct { logic [PW-1:0] exp; string tag; } exp_t;
   exp_t sb_q[$];
   int n_vec = 0, n_bad = 0;
   logic rd_pend = 1'b0;

   function automatic logic [AW-1:0] ra(int b, int off);
      return AW'((b / 3) * 256 + (b % 3) * 4 + off);
   endfunction

   task automatic chk(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [PW-1:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, logic [PW-1:0] exp, string tag);
      exp_t e;
      e.exp = exp; e.tag = tag;
      sb_q.push_back(e);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: read data is compared one cycle after the strobe
   always @(posedge clk) rd_pend <= bus_rd;
   always @(negedge clk) begin
      if (rd_pend) begin
         if (sb_q.size() == 0) chk("scoreboard underflow", 32'h1, 32'h0);
         else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.tag, bus_rdata, e.exp);
         end
      end
   end

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 pad_oe b0", pad_oe[31:0], '0);
      chk("R1 pad_oe b1", pad_oe[63:32], '0);
      chk("R1 pad_out", pad_out[31:0], '0);
      chk("R1 irqs", {29'd0, irq_any, irq_pin0, irq_pin1}, '0);
      rd(ra(1, 'h0C), 32'h0000F000, "R1 dir b1 resets to inversion");
      rd(ra(0, 'h48), '0, "R1 status b0");
      rd(ra(0, 'h9C), '0, "R1 mask b0");

      // R5 direction with inversion
      wr(ra(0, 'h0C), 32'h0000FF00);
      chk("R5 oe b0", pad_oe[31:0], 32'h0000FF00);
      wr(ra(1, 'h0C), 32'h0000F0F0);
      chk("R5 oe b1 inverted", pad_oe[63:32], 32'h000000F0);

      // R3 / R4 set and clear ports
      wr(ra(0, 'h18), 32'h00000F00);
      chk("R3 set", pad_out[31:0], 32'h00000F00);
      wr(ra(0, 'h18), 32'h00003000);
      chk("R3 set keeps zeros", pad_out[31:0], 32'h00003F00);
      wr(ra(0, 'h24), 32'h00000500);
      chk("R4 clear", pad_out[31:0], 32'h00003A00);

      // R6 level readback, mixed inputs and outputs
      ext_in[31:0] = 32'hABCDFF00;
      idle(3);
      rd(ra(0, 'h00), 32'hABCD3A00, "R6 level b0");
      ext_in[31:0] = 32'h00000000;
      idle(3);

      // R2 address map across the block boundary
      wr(ra(3, 'h0C), 32'h12345678);
      rd(12'h10C, 32'h12345678, "R2 dir b3 at 0x10C");
      chk("R2 oe b3", pad_oe[127:96], 32'h12345678);
      rd(12'h014, 32'h0, "R2 dir b2 at 0x014 untouched");
      rd(ra(0, 'h18), 32'h0, "R2 set offset reads zero");
      rd(12'h0F0, 32'h0, "R2 unmapped reads zero");

      // R7 / R10 / R11 edge capture and masking
      wr(ra(0, 'h30), 32'h1);
      wr(ra(0, 'h3C), 32'h2);
      ext_in[0] = 1'b1;
      idle(5);
      rd(ra(0, 'h48), 32'h1, "R7 rise recorded");
      chk("R10 masked irq_any", {31'd0, irq_any}, 32'h0);
      wr(ra(0, 'h9C), 32'hFFFFFFFF);
      chk("R11 irq_pin0", {30'd0, irq_pin0, irq_pin1}, 32'h2);
      chk("R11 irq_any", {31'd0, irq_any}, 32'h1);
      ext_in[1] = 1'b1;
      idle(5);
      rd(ra(0, 'h48), 32'h1, "R7 disabled rise ignored");
      ext_in[1] = 1'b0;
      idle(5);
      rd(ra(0, 'h48), 32'h3, "R7 fall recorded");
      chk("R11 irq_pin1", {31'd0, irq_pin1}, 32'h1);
      ext_in[0] = 1'b0;
      idle(5);
      rd(ra(0, 'h48), 32'h3, "R7 disabled fall ignored");

      // R8 write-one-to-clear
      wr(ra(0, 'h48), 32'h2);
      rd(ra(0, 'h48), 32'h1, "R8 partial clear");
      chk("R8 irq_pin1 low", {30'd0, irq_pin0, irq_pin1}, 32'h2);
      wr(ra(0, 'h48), 32'hFFFFFFFF);
      rd(ra(0, 'h48), 32'h0, "R8 clear all");
      chk("R8 irq_any low", {31'd0, irq_any}, 32'h0);

      // R9 collision: clear lands on the edge that sets the bit
      ext_in[0] = 1'b1;
      idle(2);
      wr(ra(0, 'h48), 32'h1);
      rd(ra(0, 'h48), 32'h1, "R9 edge wins over clear");
      wr(ra(0, 'h48), 32'h1);
      rd(ra(0, 'h48), 32'h0, "R9 later clear");

      // R11 / R10 another bank feeds only the combined line
      wr(ra(2, 'h30), 32'h20);
      wr(ra(2, 'h9C), 32'h20);
      ext_in[69] = 1'b1;
      idle(5);
      chk("R11 bank2 irq lines", {29'd0, irq_any, irq_pin0, irq_pin1}, 32'h4);
      wr(ra(2, 'h9C), 32'h0);
      chk("R10 mask drops irq_any", {31'd0, irq_any}, 32'h0);
      rd(ra(2, 'h48), 32'h20, "R10 status kept while masked");

      idle(4);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule